// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block serves the four partial-word memory instructions of a little-endian 32-bit core: load-high, load-low, store-high and store-low. The core provides the instruction kind, the two low bits of the effective byte address, the aligned memory word that contains that address, and the current value of the destination or source register. For a load, the block returns the register value with some of its bytes replaced by memory bytes. For a store, it returns a write-data word and a byte-enable mask for a single aligned word port.

The number of bytes that move depends on the byte offset inside the word. Register bytes that are not replaced keep their old value. A load-low followed by a load-high on the next word assembles a full word read from an unaligned address. Each result is captured one clock after a valid strobe and is marked by an output valid flag.

Top module: `unaligned_merge`

## Requirements
- R1: Memory is little-endian. Byte lane i of `memWord` (bits 8i+7..8i) is the byte at word address + i, and the offset k is `addrLow`. `op` encodings: 0 load-high, 1 load-low, 2 store-high, 3 store-low.
- R2: Load-high writes register lanes 3 down to 3-k with memory lanes k down to 0, in that order. Offset 2 on word 0x77665544 with register 0xDEADBEEF gives 0x665544EF. Offset 0 gives 0x44ADBEEF.
- R3: Load-low writes register lanes 0 up to 3-k with memory lanes k up to 3, so exactly 4-k lanes change. Offset 3 on word 0x33221100 with register 0xDEADBEEF gives 0xDEADBE33. Offset 1 gives 0xDE332211.
- R4: Every register lane that a load does not write comes out equal to the same lane of `regIn`.
- R5: Store-high puts register lanes 3 down to 3-k into memory lanes k down to 0. Its enables are 4'b0001, 4'b0011, 4'b0111, 4'b1111 for offsets 0 to 3.
- R6: Store-low puts register lanes 0 up to 3-k into memory lanes k up to 3. Its enables are 4'b1111, 4'b1110, 4'b1100, 4'b1000 for offsets 0 to 3.
- R7: A load gives `wrByteEn` = 0. A store gives `regOut` equal to `regIn` unchanged.
- R8: `wrData` lanes whose enable bit is 0 are zero.
- R9: Results appear on the clock edge after `inValid` is high, and `outValid` is high for exactly that cycle. While `inValid` is low, `regOut`, `wrData` and `wrByteEn` hold their values whatever the other inputs do.
- R10: After reset, `outValid`, `regOut`, `wrData` and `wrByteEn` are all zero.
- R11: Load-low at address 1 (word 0x33221100, register 0xDEADBEEF), then load-high at address 4 (word 0x77665544) on that result, yields 0x44332211.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe |
| op | input | 2 | Operation kind (see R1) |
| addrLow | input | 2 | Byte offset of the effective address within its word |
| memWord | input | 32 | Aligned memory word holding the addressed byte |
| regIn | input | 32 | Current register value |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| regOut | output | 32 | Merged register value |
| wrData | output | 32 | Store write data |
| wrByteEn | output | 4 | Store byte enables, bit i for lane i |

## Verification
The bench targets the offset extremes. At offset 3 a load-high replaces the whole register. At offset 0 a load-low does the same. An off-by-one in lane selection would leave one lane stale or overwrite a lane that should be preserved. Mirrored store masks are checked at every offset, because a design that swaps the high and low variants would write bytes on the wrong side of the address. Idle cycles carry random data on the inputs, so a design that captures without the strobe would change its held outputs. The chained load-low/load-high pair catches rotation errors that cancel out in single operations.

// File: rtl/uwm_pkg.sv
package uwm_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_LOAD_HI  = 2'd0,
    OP_LOAD_LO  = 2'd1,
    OP_STORE_HI = 2'd2,
    OP_STORE_LO = 2'd3
  } mergeOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic             isStore;
    logic [OFF_W-1:0] rot;       // lane rotation applied to the source word
    logic [LANES-1:0] laneMask;  // lanes that take rotated bytes
  } mergeCtl_t;
endpackage

// File: rtl/uwm_ctrl.sv
module uwm_ctrl
  import uwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  mergeOp_e         op,
  input  logic [OFF_W-1:0] addrLow,
  output mergeCtl_t        ctl
);
  logic             isLeft;
  logic [OFF_W-1:0] step;

  assign isLeft = (op == OP_LOAD_HI) || (op == OP_STORE_HI);
  // Left forms land one lane further round than right forms
  assign step   = addrLow + OFF_W'(isLeft);

  always_comb begin
    int offI;
    offI            = int'(addrLow);
    ctl.capture     = inValid;
    ctl.isStore     = (op == OP_STORE_HI) || (op == OP_STORE_LO);
    ctl.rot         = ctl.isStore ? (OFF_W'(0) - step) : step;
    for (int j = 0; j < LANES; j++) begin
      unique case (op)
        OP_LOAD_HI:  ctl.laneMask[j] = (j >= LANES - 1 - offI);
        OP_LOAD_LO:  ctl.laneMask[j] = (j <= LANES - 1 - offI);
        OP_STORE_HI: ctl.laneMask[j] = (j <= offI);
        default:     ctl.laneMask[j] = (j >= offI);
      endcase
    end
  end

  // R2: load-high touches offset+1 lanes
  a_r2_load_hi_count: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op == OP_LOAD_HI) |-> ($countones(ctl.laneMask) == int'(addrLow) + 1));
  // R3: load-low touches LANES-offset lanes
  a_r3_load_lo_count: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op == OP_LOAD_LO) |-> ($countones(ctl.laneMask) == LANES - int'(addrLow)));
  // R5: store-high always includes lane 0
  a_r5_store_hi_lane0: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op == OP_STORE_HI) |-> ctl.laneMask[0]);
  // R6: store-low always includes the top lane
  a_r6_store_lo_top: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op == OP_STORE_LO) |-> ctl.laneMask[LANES-1]);
endmodule

// File: rtl/uwm_datapath.sv
module uwm_datapath
  import uwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mergeCtl_t         ctl,
  input  logic [WORD_W-1:0] memWord,
  input  logic [WORD_W-1:0] regIn,
  output logic              outValid,
  output logic [WORD_W-1:0] regOut,
  output logic [WORD_W-1:0] wrData,
  output logic [LANES-1:0]  wrByteEn
);
  logic [WORD_W-1:0] srcWord;
  logic [WORD_W-1:0] rotWord;
  logic [WORD_W-1:0] nextReg;
  logic [WORD_W-1:0] nextWr;
  logic [WORD_W-1:0] maskWide;
  logic [WORD_W-1:0] enWide;
  logic              storeQ;

  assign srcWord = ctl.isStore ? regIn : memWord;

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      int idx;
      idx = (j + int'(ctl.rot)) % LANES;
      rotWord[j*BYTE_W +: BYTE_W] = srcWord[idx*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      maskWide[j*BYTE_W +: BYTE_W] = {BYTE_W{ctl.laneMask[j]}};
      enWide[j*BYTE_W +: BYTE_W]   = {BYTE_W{wrByteEn[j]}};
    end
  end

  always_comb begin
    if (ctl.isStore) begin
      nextReg = regIn;
      nextWr  = rotWord & maskWide;
    end else begin
      nextReg = (rotWord & maskWide) | (regIn & ~maskWide);
      nextWr  = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      storeQ   <= 1'b0;
      regOut   <= '0;
      wrData   <= '0;
      wrByteEn <= '0;
    end else begin
      outValid <= ctl.capture;
      if (ctl.capture) begin
        storeQ   <= ctl.isStore;
        regOut   <= nextReg;
        wrData   <= nextWr;
        wrByteEn <= ctl.isStore ? ctl.laneMask : '0;
      end
    end
  end

  // R9: valid follows the strobe by one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> outValid);
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> !outValid);
  // R9: outputs hold while idle
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(regOut) && $stable(wrData) && $stable(wrByteEn)));
  // R7: loads never write memory
  a_r7_load_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !storeQ) |-> (wrByteEn == '0));
  // R7: stores leave the register alone
  a_r7_store_keeps_reg: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && ctl.isStore) |=> (regOut == $past(regIn)));
  // R4: unselected register lanes preserved on loads
  a_r4_preserve: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !ctl.isStore) |=> (((regOut ^ $past(regIn)) & ~$past(maskWide)) == '0));
  // R8: disabled write lanes are zero
  a_r8_dead_lanes_zero: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((wrData & ~enWide) == '0));
endmodule

// File: rtl/unaligned_merge.sv
module unaligned_merge
  import uwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        op,
  input  logic [OFF_W-1:0]  addrLow,
  input  logic [WORD_W-1:0] memWord,
  input  logic [WORD_W-1:0] regIn,
  output logic              outValid,
  output logic [WORD_W-1:0] regOut,
  output logic [WORD_W-1:0] wrData,
  output logic [LANES-1:0]  wrByteEn
);
  mergeCtl_t ctl;

  uwm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .op      (mergeOp_e'(op)),
    .addrLow (addrLow),
    .ctl     (ctl)
  );

  uwm_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memWord  (memWord),
    .regIn    (regIn),
    .outValid (outValid),
    .regOut   (regOut),
    .wrData   (wrData),
    .wrByteEn (wrByteEn)
  );
endmodule

// File: tb/tb_unaligned_merge.sv
module tb_unaligned_merge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [1:0]  addrLow = 2'd0;
  logic [31:0] memWord = '0;
  logic [31:0] regIn = '0;
  logic        outValid;
  logic [31:0] regOut;
  logic [31:0] wrData;
  logic [3:0]  wrByteEn;

  int vecs = 0;
  int fails = 0;
  logic        expValid = 1'b0;
  logic [31:0] expReg = '0;
  logic [31:0] expWr = '0;
  logic [3:0]  expEn = '0;
  string       curTag = "R10";

  always #2 clk = ~clk;

  unaligned_merge dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op), .addrLow(addrLow),
    .memWord(memWord), .regIn(regIn), .outValid(outValid), .regOut(regOut),
    .wrData(wrData), .wrByteEn(wrByteEn)
  );

  // Behavioural model: walk byte addresses until the word edge
  task automatic model(input logic [1:0] o, input int k, input logic [31:0] m,
                       input logic [31:0] rin, output logic [31:0] r,
                       output logic [31:0] w, output logic [3:0] en);
    int rb;
    r = rin; w = '0; en = '0;
    case (o)
      2'd0: begin rb = 3; for (int b = k; b >= 0; b--) begin r[rb*8 +: 8] = m[b*8 +: 8]; rb--; end end
      2'd1: begin rb = 0; for (int b = k; b < 4; b++)  begin r[rb*8 +: 8] = m[b*8 +: 8]; rb++; end end
      2'd2: begin rb = 3; for (int b = k; b >= 0; b--) begin w[b*8 +: 8] = rin[rb*8 +: 8]; en[b] = 1'b1; rb--; end end
      default: begin rb = 0; for (int b = k; b < 4; b++) begin w[b*8 +: 8] = rin[rb*8 +: 8]; en[b] = 1'b1; rb++; end end
    endcase
  endtask

  task automatic compare();
    vecs++;
    if (outValid !== expValid || regOut !== expReg || wrData !== expWr || wrByteEn !== expEn) begin
      fails++;
      $display("FAIL %s: got v=%0b reg=%h wr=%h en=%b expected v=%0b reg=%h wr=%h en=%b",
               curTag, outValid, regOut, wrData, wrByteEn, expValid, expReg, expWr, expEn);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [1:0] k, input logic [31:0] m,
                       input logic [31:0] rin, input string tag);
    logic [31:0] r, w;
    logic [3:0] en;
    @(negedge clk);
    compare();
    inValid = 1'b1; op = o; addrLow = k; memWord = m; regIn = rin;
    model(o, int'(k), m, rin, r, w, en);
    expValid = 1'b1; expReg = r; expWr = w; expEn = en; curTag = tag;
  endtask

  // R9: idle cycle with garbage on the data inputs
  task automatic idle(input string tag);
    @(negedge clk);
    compare();
    inValid = 1'b0; op = 2'($urandom); addrLow = 2'($urandom);
    memWord = $urandom; regIn = $urandom;
    expValid = 1'b0; curTag = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();               // R10 reset state
    rstN = 1'b1;
    idle("R10");
    // R2 examples
    apply(2'd0, 2'd2, 32'h77665544, 32'hDEADBEEF, "R2");
    apply(2'd0, 2'd0, 32'h77665544, 32'hDEADBEEF, "R2");
    apply(2'd0, 2'd3, 32'h77665544, 32'hDEADBEEF, "R2");
    // R3 examples
    apply(2'd1, 2'd3, 32'h33221100, 32'hDEADBEEF, "R3");
    apply(2'd1, 2'd1, 32'h33221100, 32'hDEADBEEF, "R3");
    apply(2'd1, 2'd0, 32'h33221100, 32'hDEADBEEF, "R3");
    // R11 chained pair
    apply(2'd1, 2'd1, 32'h33221100, 32'hDEADBEEF, "R11");
    apply(2'd0, 2'd0, 32'h77665544, 32'hDE332211, "R11");
    idle("R9");
    @(negedge clk);
    vecs++;
    if (regOut !== 32'h44332211) begin
      fails++;
      $display("FAIL R11: got %h expected 44332211", regOut);
    end
    // R5 / R6 every offset
    for (int k = 0; k < 4; k++) apply(2'd2, 2'(k), 32'hA5A5A5A5, 32'h44332211, "R5");
    for (int k = 0; k < 4; k++) apply(2'd3, 2'(k), 32'hA5A5A5A5, 32'h44332211, "R6");
    idle("R9");
    idle("R9");
    // R7 / R8 / R4 / R1 random
    for (int i = 0; i < 300; i++) begin
      logic [1:0] o;
      o = 2'($urandom);
      if (i % 5 == 4) idle("R9");
      else apply(o, 2'($urandom), $urandom, $urandom, o[1] ? "R8" : "R4");
    end
    apply(2'd2, 2'd1, $urandom, 32'hCAFEF00D, "R7");
    apply(2'd0, 2'd1, $urandom, $urandom, "R1");
    idle("R7");
    idle("R9");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule